// File: doc/BRIEF.md
# Bus Master Interrupt Controller

This block turns bus-mastering completion and failure events into an interrupt request. Three event sources feed it: the read transfer count reaching zero, the write transfer count reaching zero, and a bus error. A bus error is either a target abort or a master abort. Each event arrives as a one-cycle pulse from counters and abort detection that sit outside the block. Every source has a sticky status bit. Software reads the bits to find the cause and clears them by writing ones.

Two active-low interrupt outputs exist. The host-side output is used when the host started the bus mastering, and the local-side output is used when the local side started it. A mode input picks which one is active. The read-count and write-count sources each have their own enable. The error source is only effective when at least one of those two enables is set. A global disable masks both outputs.

Top module: `bm_irq_ctrl`

## Requirements
- R1: After reset, all status bits are 0, and `hostIntN` and `localIntN` are both 1.
- R2: Each source sets its status bit on the clock edge that samples its event pulse, whatever the enables are. `rdCountZero` sets bit 0 and `wrCountZero` sets bit 1. Either `targetAbort` or `masterAbort` sets bit 2.
- R3: When `clrWe` is 1, each status bit whose `clrMask` bit is 1 is cleared on that edge. Bits whose mask bit is 0 are left unchanged. `clrMask` is ignored when `clrWe` is 0.
- R4: Status bits are sticky and keep their value until they are cleared. If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R5: Status bit 2 (error) raises an interrupt only when `rdIntEn` or `wrIntEn` is 1. With both enables at 0, neither output is asserted, whatever the status holds.
- R6: Status bit 0 raises an interrupt only when `rdIntEn` is 1, and status bit 1 only when `wrIntEn` is 1. The interrupt follows the status bits and enables with no added register, so it is asserted in the same cycle the status bit becomes visible.
- R7: When `localInitiated` is 0, a pending interrupt drives `hostIntN` to 0 and `localIntN` stays 1. When `localInitiated` is 1, the roles of the two outputs are swapped.
- R8: While `intDisable` is 1, both outputs stay at 1. The status bits keep their values and still record events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdCountZero | input | 1 | Pulse: read transfer count reached zero |
| wrCountZero | input | 1 | Pulse: write transfer count reached zero |
| targetAbort | input | 1 | Pulse: target abort seen while mastering |
| masterAbort | input | 1 | Pulse: master abort seen while mastering |
| localInitiated | input | 1 | 1 = local side started mastering, 0 = host did |
| rdIntEn | input | 1 | Read-count interrupt enable |
| wrIntEn | input | 1 | Write-count interrupt enable |
| intDisable | input | 1 | Global interrupt mask |
| clrWe | input | 1 | Status write-one-to-clear strobe |
| clrMask | input | 3 | Bits to clear (bit0 read, bit1 write, bit2 error) |
| status | output | 3 | Sticky status (bit0 read, bit1 write, bit2 error) |
| hostIntN | output | 1 | Active-low host-side interrupt |
| localIntN | output | 1 | Active-low local-side interrupt |

## Verification
The bench raises an error with both count enables off and checks that both outputs stay high. It then sets one enable and checks that the interrupt appears; a design that gates errors by their own enable, or not at all, fails one of these two steps. Set and clear are applied to the same bit in the same cycle. A design where the clear wins would drop a completion event. Partial clear masks are used to show that other bits survive, and a clear mask is applied with `clrWe` low to show that it has no effect. The mode input is toggled while an interrupt is pending and the global disable is asserted, to catch outputs that are not steered, not masked, or that disturb the status.

// File: rtl/bm_irq_pkg.sv
package bm_irq_pkg;
  localparam int SRC_W   = 3;
  localparam int SRC_RD  = 0;
  localparam int SRC_WR  = 1;
  localparam int SRC_ERR = 2;

  typedef struct packed {
    logic [SRC_W-1:0] setMask;
    logic [SRC_W-1:0] clrMask;
    logic [SRC_W-1:0] enMask;
    logic             selLocal;
  } irqStrobe_t;
endpackage

// File: rtl/bm_irq_ctrl_logic.sv
module bm_irq_ctrl_logic
  import bm_irq_pkg::*;
(
  input  logic             rdCountZero,
  input  logic             wrCountZero,
  input  logic             targetAbort,
  input  logic             masterAbort,
  input  logic             localInitiated,
  input  logic             rdIntEn,
  input  logic             wrIntEn,
  input  logic             intDisable,
  input  logic             clrWe,
  input  logic [SRC_W-1:0] clrMask,
  output irqStrobe_t       strobe
);
  logic errGate;

  always_comb begin
    errGate = rdIntEn | wrIntEn;
    strobe = '0;
    strobe.setMask[SRC_RD]  = rdCountZero;
    strobe.setMask[SRC_WR]  = wrCountZero;
    strobe.setMask[SRC_ERR] = targetAbort | masterAbort;
    strobe.clrMask          = clrWe ? clrMask : '0;
    if (!intDisable) begin
      strobe.enMask[SRC_RD]  = rdIntEn;
      strobe.enMask[SRC_WR]  = wrIntEn;
      strobe.enMask[SRC_ERR] = errGate;
    end
    strobe.selLocal = localInitiated;
  end
endmodule

// File: rtl/bm_irq_datapath.sv
module bm_irq_datapath
  import bm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobe_t       strobe,
  output logic [SRC_W-1:0] statusQ,
  output logic             hostIntN,
  output logic             localIntN
);
  logic pending;

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= strobe.setMask[i] | (statusQ[i] & ~strobe.clrMask[i]);
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setMask[i] |=> statusQ[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrMask[i] && !strobe.setMask[i]) |=> !statusQ[i]);
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !strobe.clrMask[i]) |=> statusQ[i]);
  end

  always_comb begin
    pending   = |(statusQ & strobe.enMask);
    hostIntN  = ~(pending & ~strobe.selLocal);
    localIntN = ~(pending & strobe.selLocal);
  end

  p_steer_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selLocal ? hostIntN : localIntN);
endmodule

// File: rtl/bm_irq_ctrl.sv
module bm_irq_ctrl
  import bm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdCountZero,
  input  logic             wrCountZero,
  input  logic             targetAbort,
  input  logic             masterAbort,
  input  logic             localInitiated,
  input  logic             rdIntEn,
  input  logic             wrIntEn,
  input  logic             intDisable,
  input  logic             clrWe,
  input  logic [SRC_W-1:0] clrMask,
  output logic [SRC_W-1:0] status,
  output logic             hostIntN,
  output logic             localIntN
);
  irqStrobe_t strobe;

  bm_irq_ctrl_logic u_ctrl (
    .rdCountZero(rdCountZero), .wrCountZero(wrCountZero),
    .targetAbort(targetAbort), .masterAbort(masterAbort),
    .localInitiated(localInitiated), .rdIntEn(rdIntEn), .wrIntEn(wrIntEn),
    .intDisable(intDisable), .clrWe(clrWe), .clrMask(clrMask), .strobe(strobe)
  );

  bm_irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusQ(status),
    .hostIntN(hostIntN), .localIntN(localIntN)
  );

  p_err_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rdIntEn && !wrIntEn) |-> (hostIntN && localIntN));
  p_disable_r8: assert property (@(posedge clk) disable iff (!rstN)
    intDisable |-> (hostIntN && localIntN));
  p_rd_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdCountZero |=> status[SRC_RD]);
  p_abort_r2: assert property (@(posedge clk) disable iff (!rstN)
    (targetAbort || masterAbort) |=> status[SRC_ERR]);
  p_rd_int_r6: assert property (@(posedge clk) disable iff (!rstN)
    (status[SRC_RD] && rdIntEn && !intDisable) |-> !(hostIntN && localIntN));
endmodule

// File: tb/bm_irq_ctrl_bench.sv
`timescale 1ns/1ps
module bm_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdCountZero = 0, wrCountZero = 0, targetAbort = 0, masterAbort = 0;
  logic localInitiated = 0, rdIntEn = 0, wrIntEn = 0, intDisable = 0, clrWe = 0;
  logic [2:0] clrMask = '0;
  logic [2:0] status;
  logic hostIntN, localIntN;

  int checks = 0;
  int fails = 0;
  logic [2:0] expStatus = '0;

  typedef struct {
    logic [2:0] st;
    logic       hN;
    logic       lN;
    string      req;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  bm_irq_ctrl u_bm_irq_ctrl (
    .clk(clk), .rstN(rstN), .rdCountZero(rdCountZero), .wrCountZero(wrCountZero),
    .targetAbort(targetAbort), .masterAbort(masterAbort),
    .localInitiated(localInitiated), .rdIntEn(rdIntEn), .wrIntEn(wrIntEn),
    .intDisable(intDisable), .clrWe(clrWe), .clrMask(clrMask),
    .status(status), .hostIntN(hostIntN), .localIntN(localIntN)
  );

  task automatic compare(input logic [2:0] st, input logic hN, input logic lN, input string req);
    checks++;
    if (status !== st || hostIntN !== hN || localIntN !== lN) begin
      fails++;
      $display("FAIL %s: status=%b host=%b local=%b expected status=%b host=%b local=%b",
               req, status, hostIntN, localIntN, st, hN, lN);
    end
  endtask

  // driver: apply one cycle of stimulus and push the predicted result
  task automatic step(input logic rd, input logic wr, input logic ta, input logic ma,
                      input logic cw, input logic [2:0] cm, input string req);
    logic [2:0] en;
    logic pend;
    item_t it;
    @(negedge clk);
    rdCountZero = rd; wrCountZero = wr; targetAbort = ta; masterAbort = ma;
    clrWe = cw; clrMask = cm;
    expStatus = {ta | ma, wr, rd} | (expStatus & ~(cw ? cm : 3'b000));
    en = {rdIntEn | wrIntEn, wrIntEn, rdIntEn};
    pend = (|(expStatus & en)) && !intDisable;
    it.st = expStatus;
    it.hN = !(pend && !localInitiated);
    it.lN = !(pend && localInitiated);
    it.req = req;
    q.push_back(it);
    @(negedge clk);
    rdCountZero = 0; wrCountZero = 0; targetAbort = 0; masterAbort = 0;
    clrWe = 0; clrMask = '0;
  endtask

  // monitor: compare after each edge that has a pending prediction
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compare(it.st, it.hN, it.lN, it.req);
    end
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(3'b000, 1'b1, 1'b1, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compare(3'b000, 1'b1, 1'b1, "R1 after reset");

    rdIntEn = 1;
    step(1,0,0,0, 0,3'b000, "R2 R6 R7 read count event to host");
    step(0,0,0,0, 0,3'b000, "R4 sticky hold");
    step(0,0,0,0, 0,3'b111, "R3 mask ignored without clrWe");
    step(0,0,0,0, 1,3'b001, "R3 clear read bit");
    step(0,1,0,0, 0,3'b000, "R6 write bit without write enable");
    wrIntEn = 1;
    step(0,0,0,0, 0,3'b000, "R6 write enable raises interrupt");
    step(0,0,0,0, 1,3'b101, "R3 zero mask bit leaves write bit");
    step(0,0,0,0, 1,3'b010, "R3 clear write bit");
    rdIntEn = 0; wrIntEn = 0;
    step(0,0,1,0, 0,3'b000, "R5 target abort gated off");
    rdIntEn = 1;
    step(0,0,0,0, 0,3'b000, "R5 error effective with read enable");
    rdIntEn = 0; wrIntEn = 1;
    step(0,0,0,0, 0,3'b000, "R5 error effective with write enable");
    step(0,0,0,0, 1,3'b100, "R3 clear error bit");
    step(0,0,0,1, 0,3'b000, "R2 master abort sets error");
    localInitiated = 1;
    step(0,0,0,0, 0,3'b000, "R7 local side steering");
    intDisable = 1;
    step(1,0,0,0, 0,3'b000, "R8 disable masks, status still records");
    intDisable = 0;
    step(0,0,0,0, 0,3'b000, "R8 release disable");
    step(1,0,0,0, 1,3'b001, "R4 set wins over same-cycle clear");
    step(0,0,0,0, 1,3'b111, "R3 clear all");
    localInitiated = 0; rdIntEn = 1;
    step(1,1,1,1, 0,3'b000, "R2 all sources together");
    step(0,0,0,0, 1,3'b111, "R3 clear all again");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule